// File: doc/BRIEF.md
# Quad Programmable Down-Counter with Vectored Interrupts

This peripheral holds four independent down-counter channels behind a plain CPU I/O port. A two-bit address selects the channel, and each channel is set up with a control byte. When that byte asks for it, the next write to the same channel address carries the reload value. Each channel then counts down in one of two ways. In timer mode it steps on a divided system clock. In counter mode it steps on synchronised rising edges of its own trigger pin. Whenever a channel reaches zero it reloads, pulses a zero-count output and, if enabled, raises an interrupt request.

A single vector register is shared by all channels. During an interrupt acknowledge the block presents an 8-bit byte made of the stored vector bits and the number of the winning channel. The CPU uses this byte as the low half of a 16-bit pointer to the service routine. A CPU read of any channel address returns the live count of that channel.

Top module: `quad_downcounter`

## Requirements
- R1: After a control byte with bit 2 set, the next write to that channel is taken as the reload value. It is never taken as a control byte, and at address 0 it is never taken as a vector write.
- R2: A reload value of 0 counts as 256. A read of such a freshly loaded channel returns 0, and one count step later it returns 255.
- R3: A reload value written while the channel is running does not change the current count. The running period completes with the old value, and the new value applies from the following period.
- R4: A write to address 0 with data bit 0 clear, while channel 0 is not waiting for a reload value, stores data bits 7:3 as the vector base. Data bits 2:0 are discarded, and such writes to addresses 1 to 3 are ignored.
- R5: The vector output is the stored base in bits 7:3, the binary number of the granted channel in bits 2:1, and 0 in bit 0.
- R6: Channel 0 has the highest priority among pending channels and channel 3 the lowest. An acknowledge clears the pending flag of the granted channel only.
- R7: In timer mode (control bit 6 clear) the channel steps once every 16 system clocks, so zero-count pulses repeat every 16 × reload clocks.
- R8: In counter mode (control bit 6 set) the channel steps once per rising edge of its trigger input after a two-flop synchroniser.
- R9: Stepping from 1 reloads the value in the same clock and gives a one-cycle zero-count pulse. The pending flag is set only if control bit 7 was set. The interrupt request is high while any flag is pending.
- R10: A read returns the low 8 bits of the addressed channel's count.
- R11: A control byte with bit 1 set stops the channel and clears its pending flag. A stopped channel holds its count and gives no zero-count pulse.
- R12: After reset all channels are stopped with a count of 0, nothing is pending, and the vector output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| addr | input | 2 | Channel select |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Count of the addressed channel |
| trig | input | 4 | External trigger, one bit per channel |
| zc | output | 4 | One-cycle zero-count pulse per channel |
| irq | output | 1 | Interrupt request |
| int_ack | input | 1 | Interrupt acknowledge, one cycle |
| vec | output | 8 | Vector byte for the granted channel |

## Verification
The checker watches several properties on every cycle: the zero-count pulse width, that a pending flag only rises together with its channel's zero-count pulse, that a stopped channel stays silent, the priority order and fixed bit 0 of the vector, and the clearing of the granted flag on acknowledge. Other behaviours only show over the bench's scenarios. These are the exact 16 × reload period, the 256 meaning of zero, the deferred reload across a running period, the routing of the write after a control byte, and the trigger-driven count compared with a bench model under random reload and pulse counts.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  localparam int DW  = 8;            // data and reload width
  localparam int CW  = DW + 1;       // count width (holds 256)
  localparam int AW  = 2;            // channel address width
  localparam int NCH = 1 << AW;      // channel count

  // control byte bit positions
  localparam int CB_KIND  = 0;   // 1 = control byte, 0 = vector byte
  localparam int CB_STOP  = 1;
  localparam int CB_TCNXT = 2;
  localparam int CB_CMODE = 6;
  localparam int CB_IEN   = 7;

  // reload byte to count span, 0 stands for 256
  function automatic logic [CW-1:0] tc_span(input logic [DW-1:0] d);
    return (d == '0) ? CW'(1 << DW) : {1'b0, d};
  endfunction

  // vector byte: stored base, channel number, zero lsb
  function automatic logic [DW-1:0] vec_byte(input logic [DW-AW-2:0] base,
                                             input logic [AW-1:0] id);
    return {base, id, 1'b0};
  endfunction
endpackage

// File: rtl/qdc_prescaler.sv
module qdc_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/qdc_channel.sv
module qdc_channel
  import qdc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  input  logic          trig,
  input  logic          ack_clr,
  output logic [DW-1:0] count_o,
  output logic          zc_o,
  output logic          pend_o,
  output logic          run_o,
  output logic          exp_tc_o
);
  logic          run, exp_tc, int_en, cnt_mode, pend, zc;
  logic [CW-1:0] tc_q, cnt;
  logic [2:0]    sync;
  logic          rise, step, hit;

  assign rise = sync[1] & ~sync[2];
  assign step = run & (cnt_mode ? rise : tick);
  assign hit  = step & (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; exp_tc <= 1'b0; int_en <= 1'b0; cnt_mode <= 1'b0;
      pend <= 1'b0; zc <= 1'b0; tc_q <= '0; cnt <= '0; sync <= '0;
    end else begin
      sync <= {sync[1:0], trig};
      zc   <= hit;
      if (hit)       cnt <= tc_q;
      else if (step) cnt <= cnt - 1'b1;
      if (hit && int_en) pend <= 1'b1;
      else if (ack_clr)  pend <= 1'b0;
      if (wr) begin
        if (exp_tc) begin
          tc_q   <= tc_span(wdata);
          exp_tc <= 1'b0;
          if (!run) begin
            cnt <= tc_span(wdata);
            run <= 1'b1;
          end
        end else if (wdata[CB_KIND]) begin
          int_en   <= wdata[CB_IEN];
          cnt_mode <= wdata[CB_CMODE];
          exp_tc   <= wdata[CB_TCNXT];
          if (wdata[CB_STOP]) begin
            run  <= 1'b0;
            pend <= 1'b0;
          end
        end
      end
    end
  end

  assign count_o  = cnt[DW-1:0];
  assign zc_o     = zc;
  assign pend_o   = pend;
  assign run_o    = run;
  assign exp_tc_o = exp_tc;
endmodule

// File: rtl/qdc_irq_arb.sv
module qdc_irq_arb
  import qdc_pkg::*;
(
  input  logic [NCH-1:0] pend,
  input  logic           ack,
  output logic           irq,
  output logic [AW-1:0]  id,
  output logic [NCH-1:0] clr
);
  always_comb begin
    id = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) id = AW'(i);
    end
  end

  assign irq = |pend;
  assign clr = (ack && irq) ? (NCH'(1) << id) : '0;
endmodule

// File: rtl/quad_downcounter.sv
module quad_downcounter
  import qdc_pkg::*;
#(
  parameter int PRESCALE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [3:0]    trig,
  output logic [3:0]    zc,
  output logic          irq,
  input  logic          int_ack,
  output logic [7:0]    vec
);
  localparam int VBW = DW - AW - 1;   // stored vector bits

  logic            tick;
  logic [NCH-1:0]  pend_w, run_w, exp_w, clr_w, zc_w;
  logic [DW-1:0]   cnt_arr [NCH];
  logic [AW-1:0]   gnt_id;
  logic [VBW-1:0]  vbase;
  logic            vec_we;

  qdc_prescaler #(.DIV(PRESCALE)) u_pre (.clk(clk), .rst_n(rst_n), .tick(tick));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    qdc_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && addr == AW'(g)),
      .wdata(wdata), .tick(tick), .trig(trig[g]), .ack_clr(clr_w[g]),
      .count_o(cnt_arr[g]), .zc_o(zc_w[g]), .pend_o(pend_w[g]),
      .run_o(run_w[g]), .exp_tc_o(exp_w[g])
    );
  end

  // vector write only when channel 0 is not awaiting its reload byte
  assign vec_we = wr_en && addr == '0 && !wdata[CB_KIND] && !exp_w[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      vbase <= '0;
    else if (vec_we) vbase <= wdata[DW-1:DW-VBW];
  end

  qdc_irq_arb u_arb (.pend(pend_w), .ack(int_ack), .irq(irq), .id(gnt_id), .clr(clr_w));

  assign rdata = cnt_arr[addr];
  assign zc    = zc_w;
  assign vec   = vec_byte(vbase, gnt_id);
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       int_ack,
  input logic       irq,
  input logic [7:0] vec,
  input logic [3:0] zc,
  input logic [3:0] pend,
  input logic [3:0] run
);
  // R9
  zc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc & $past(zc)) == 4'b0000);

  // R9
  pend_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~zc) == 4'b0000);

  // R11
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc & ~$past(run)) == 4'b0000);

  // R5
  vec_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec[0] == 1'b0 && pend[vec[2:1]]));

  // R6
  priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & ((4'b0001 << vec[2:1]) - 4'b0001)) == 4'b0000));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && irq) |=> (!pend[$past(vec[2:1])] || zc[$past(vec[2:1])]));
endmodule

bind quad_downcounter qdc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .irq(irq), .vec(vec),
  .zc(zc), .pend(pend_w), .run(run_w)
);

// File: tb/quad_downcounter_bench.sv
module quad_downcounter_bench;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, int_ack = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, vec;
  logic [3:0] trig = '0, zc;
  logic       irq;
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  quad_downcounter u_quad_downcounter (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trig(trig), .zc(zc), .irq(irq),
    .int_ack(int_ack), .vec(vec));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int span(input logic [7:0] d);
    return (d == 0) ? 256 : int'(d);
  endfunction
  function automatic logic [7:0] exp_vec(input logic [7:0] base, input int ch);
    return (base & 8'hF8) | 8'((ch & 3) << 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = 2'(a); #1 v = int'(rdata);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); trig[ch] = 1'b1;
    repeat (2) @(negedge clk); trig[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_zc(input int ch, output int t);
    do @(negedge clk); while (!zc[ch]);
    t = cyc;
  endtask

  task automatic ack();
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int v, t0, t1, t2, m, k, tc;
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    @(negedge clk);
    chk(irq == 1'b0 && zc == 4'b0, "R12 idle", int'(irq), 0);
    chk(vec == 8'h00, "R12 vec", int'(vec), 0);
    for (int c = 0; c < 4; c++) begin
      rd(c, v); chk(v == 0, "R12 count", v, 0);
    end

    // R4 vector write keeps bits 7:3 only
    wr(0, 8'hAE);
    @(negedge clk); chk(vec == 8'hA8, "R4 vec store", int'(vec), 8'hA8);
    wr(1, 8'hF0);
    @(negedge clk); chk(vec == 8'hA8, "R4 other addr ignored", int'(vec), 8'hA8);
    rd(1, v); chk(v == 0, "R4 ch1 untouched", v, 0);

    // R1 byte after control is the reload, not a vector or control
    wr(0, 8'h45); wr(0, 8'h10);
    @(negedge clk); chk(vec == 8'hA8, "R1 vec unchanged", int'(vec), 8'hA8);
    rd(0, v); chk(v == 16, "R1 reload taken R10", v, 16);
    wr(2, 8'h45); wr(2, 8'h07);
    rd(2, v); chk(v == 7, "R1 control-like reload", v, 7);

    // R2 zero means 256
    wr(2, 8'h47); wr(2, 8'h00);
    rd(2, v); chk(v == 0, "R2 load 256", v, 0);
    pulse(2);
    rd(2, v); chk(v == 255, "R2 after step", v, 255);

    // R8 random reloads and pulse counts against a model
    for (int it = 0; it < 30; it++) begin
      d = 8'($urandom_range(0, 8));
      k = $urandom_range(0, 12);
      tc = span(d);
      wr(1, 8'h47); wr(1, d);
      m = tc;
      for (int p = 0; p < k; p++) begin
        pulse(1);
        m = (m == 1) ? tc : m - 1;
      end
      rd(1, v); chk(v == (m & 8'hFF), "R8 trigger count", v, m & 8'hFF);
    end

    // R7 and R9 timer period and pulse width
    wr(0, 8'h07); wr(0, 8'h03);
    wait_zc(0, t0);
    @(negedge clk); chk(zc[0] == 1'b0, "R9 one-cycle pulse", int'(zc[0]), 0);
    wait_zc(0, t1);
    chk(t1 - t0 == 48, "R7 period 16x3", t1 - t0, 48);
    wr(0, 8'h07); wr(0, 8'h00);
    wait_zc(0, t0); wait_zc(0, t1);
    chk(t1 - t0 == 4096, "R2 timer 256 period", t1 - t0, 4096);
    wr(0, 8'h03);

    // R3 deferred reload
    wr(3, 8'h05); wr(3, 8'h04);
    wait_zc(3, t0);
    repeat (20) @(negedge clk);
    wr(3, 8'h05); wr(3, 8'h02);
    wait_zc(3, t1); wait_zc(3, t2);
    chk(t1 - t0 == 64, "R3 old period kept", t1 - t0, 64);
    chk(t2 - t1 == 32, "R3 new period", t2 - t1, 32);

    // R11 stop holds count and stays silent
    wr(3, 8'h03);
    rd(3, t0);
    m = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk); if (zc[3]) m++;
    end
    rd(3, t1);
    chk(t1 == t0, "R11 count held", t1, t0);
    chk(m == 0, "R11 no pulse", m, 0);

    // R5 R6 R9 vectored interrupts and priority
    wr(1, 8'hC7); wr(1, 8'h01);
    wr(2, 8'hC7); wr(2, 8'h01);
    pulse(2);
    @(negedge clk); chk(irq == 1'b1, "R9 irq raised", int'(irq), 1);
    chk(vec == exp_vec(8'hA8, 2), "R5 vec ch2", int'(vec), int'(exp_vec(8'hA8, 2)));
    pulse(1);
    chk(vec == exp_vec(8'hA8, 1), "R6 ch1 wins", int'(vec), int'(exp_vec(8'hA8, 1)));
    ack();
    chk(irq == 1'b1 && vec == exp_vec(8'hA8, 2), "R6 ch2 left",
        int'(vec), int'(exp_vec(8'hA8, 2)));
    ack();
    chk(irq == 1'b0, "R6 all cleared", int'(irq), 0);
    wr(1, 8'h05); wr(1, 8'h01);
    pulse(1);
    chk(irq == 1'b0, "R9 disabled no pend", int'(irq), 0);

    finish_run();
  end
endmodule